// File: doc/BRIEF.md
# Configurable Registered Bidirectional Pad Cell

This block sits between core logic and one package pin per bit. It has three paths, and each can be built combinational or registered: the value the core wants to drive, the control that decides whether the pad is driven, and the value read back from the pad. The read path can also be built as a transparent latch. Parameters are fixed when the cell is built. They select the clock edge of every register, the gate polarity of the input latch, the reset value of every register, and how the drive control is encoded.

The core receives two read values. `pad_fb` is the raw pad value at all times. `core_din` is the same value after the input path's register or latch, or unchanged when that path is combinational. Because both come from one pad, the core can use the early and the late copy together.

The pad is modelled as an inout wire. When the cell does not drive it, it floats to high impedance. The pins are plain control and status pins, so there is no valid/ready handshake.

Top module: `pad_io_cell`

## Requirements
- R1: A path built with mode PM_COMB has no register. `pad` follows `core_dout` and `drv_ctl` within the same cycle, and `core_din` follows `pad`.
- R2: Each register uses the rising edge of its clock when its NEG parameter is 0, and the falling edge when it is 1. A change set up while the clock is high reaches a rising-edge register only at the next rising edge.
- R3: With the input in PM_LATCH mode, `core_din` tracks `pad` while the gate is open. The gate is open when `clk_in` is high (`LATCH_GATE_LOW`=0) or low (=1), and the effective input enable is 1. While the gate is closed, `core_din` holds its value.
- R4: A register loads only in a cycle where its enable is 1. The enable is `in_ce | io_ce` for the input register, `out_ce | io_ce` for the output register, and `oe_ce` alone for the drive-control register.
- R5: After reset, the input and output data registers hold all 0 by default. With `IN_RST_ONE`/`OUT_RST_ONE` = 1 they hold all 1.
- R6: After reset, the drive-control register leaves the pad undriven by default (`OE_RST_HIZ`=1). With `OE_RST_HIZ`=0 it drives the pad.
- R7: `drv_ctl` bit asserted means drive when `CTL_IS_TRISTATE`=0, and float when it is 1. The asserted level is 1 when `CTL_ACTIVE_LOW`=0, and 0 otherwise.
- R8: `pad_fb` always equals the pad value. A registered `core_din` shows the value captured at the last active edge, so both are present together.
- R9: Reset is synchronous to each register's own clock and overrides its enable.
- R10: With default reset values the pad is high impedance during reset, and it stays so afterwards until drive is requested. While driven, `pad_fb` equals the output path value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input register clock, or input latch gate |
| clk_out | input | 1 | Output register clock |
| clk_oe | input | 1 | Drive-control register clock |
| rst | input | 1 | Synchronous reset, active high |
| in_ce | input | 1 | Input register enable |
| out_ce | input | 1 | Output register enable |
| oe_ce | input | 1 | Drive-control register enable |
| io_ce | input | 1 | Shared enable for the input and output registers |
| core_dout | input | WIDTH | Value to drive onto the pad |
| drv_ctl | input | WIDTH | Per-bit drive control, encoding set by parameters |
| pad | inout | WIDTH | Package pin |
| core_din | output | WIDTH | Pad value after the input path |
| pad_fb | output | WIDTH | Raw pad value |

## Verification
The hardest thing to show from the ports is the clock-edge choice. Rising-edge and falling-edge registers both settle within one clock period, so their outputs look the same at a coarse sample point. The bench changes the inputs while the clock is high. It then samples once between that point and the falling edge, and once just after the falling edge. A falling-edge instance has changed by the second sample and a rising-edge instance has not. The latch gate is probed the same way: the pad is changed during the high phase and during the low phase, and `core_din` is read each time.

// File: rtl/padcell_pkg.sv
package padcell_pkg;
  typedef enum logic [1:0] {
    PM_COMB  = 2'd0,
    PM_FLOP  = 2'd1,
    PM_LATCH = 2'd2
  } path_mode_e;
endpackage

// File: rtl/padcell_drvctl.sv
module padcell_drvctl #(
  parameter int WIDTH = 4,
  parameter bit IS_TRISTATE = 1'b0,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic [WIDTH-1:0] ctl,
  output logic [WIDTH-1:0] hiz
);
  localparam logic [WIDTH-1:0] LEVEL_FLIP = {WIDTH{ACTIVE_LOW}};
  logic [WIDTH-1:0] asserted;

  // normalise the asserted level first, then the meaning of "asserted"
  assign asserted = ctl ^ LEVEL_FLIP;
  generate
    if (IS_TRISTATE) begin : g_tri
      assign hiz = asserted;
    end else begin : g_en
      assign hiz = ~asserted;
    end
  endgenerate
endmodule

// File: rtl/padcell_flop.sv
module padcell_flop #(
  parameter int WIDTH = 4,
  parameter bit NEG = 1'b0,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (NEG) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (ce) q <= d;
      end
      assert_neg_hold_R4: assert property (@(negedge clk) disable iff (rst)
        !ce |=> $stable(q));
      assert_neg_load_R2: assert property (@(negedge clk) disable iff (rst)
        ce |=> (q === $past(d)));
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (ce) q <= d;
      end
      assert_pos_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));
      assert_pos_load_R2: assert property (@(posedge clk) disable iff (rst)
        ce |=> (q === $past(d)));
    end
  endgenerate
endmodule

// File: rtl/padcell_latch.sv
module padcell_latch #(
  parameter int WIDTH = 4,
  parameter bit GATE_LOW = 1'b0,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             gate_clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic open_now;

  // R3: transparent on the selected gate level while enabled
  assign open_now = (gate_clk ^ GATE_LOW) & ce;

  always_latch begin
    if (rst)           q = RST_VAL;
    else if (open_now) q = d;
  end
endmodule

// File: rtl/pad_io_cell.sv
module pad_io_cell #(
  parameter int WIDTH = 4,
  parameter padcell_pkg::path_mode_e IN_MODE  = padcell_pkg::PM_FLOP,
  parameter padcell_pkg::path_mode_e OUT_MODE = padcell_pkg::PM_FLOP,
  parameter padcell_pkg::path_mode_e OE_MODE  = padcell_pkg::PM_FLOP,
  parameter bit IN_NEG = 1'b0,
  parameter bit OUT_NEG = 1'b0,
  parameter bit OE_NEG = 1'b0,
  parameter bit LATCH_GATE_LOW = 1'b0,
  parameter bit IN_RST_ONE = 1'b0,
  parameter bit OUT_RST_ONE = 1'b0,
  parameter bit OE_RST_HIZ = 1'b1,
  parameter bit CTL_IS_TRISTATE = 1'b0,
  parameter bit CTL_ACTIVE_LOW = 1'b0
) (
  input  logic             clk_in,
  input  logic             clk_out,
  input  logic             clk_oe,
  input  logic             rst,
  input  logic             in_ce,
  input  logic             out_ce,
  input  logic             oe_ce,
  input  logic             io_ce,
  input  logic [WIDTH-1:0] core_dout,
  input  logic [WIDTH-1:0] drv_ctl,
  inout  wire  [WIDTH-1:0] pad,
  output logic [WIDTH-1:0] core_din,
  output logic [WIDTH-1:0] pad_fb
);
  import padcell_pkg::*;

  localparam logic [WIDTH-1:0] IN_RST  = {WIDTH{IN_RST_ONE}};
  localparam logic [WIDTH-1:0] OUT_RST = {WIDTH{OUT_RST_ONE}};
  localparam logic [WIDTH-1:0] OE_RST  = {WIDTH{OE_RST_HIZ}};

  logic             in_en;
  logic             out_en;
  logic [WIDTH-1:0] hiz_req;
  logic [WIDTH-1:0] hiz_now;
  logic [WIDTH-1:0] out_now;

  // R4: the shared enable feeds both data registers
  assign in_en  = in_ce | io_ce;
  assign out_en = out_ce | io_ce;

  padcell_drvctl #(
    .WIDTH(WIDTH), .IS_TRISTATE(CTL_IS_TRISTATE), .ACTIVE_LOW(CTL_ACTIVE_LOW)
  ) u_drvctl (
    .ctl(drv_ctl), .hiz(hiz_req)
  );

  // drive-control path: the register holds "float" as 1
  generate
    if (OE_MODE == PM_COMB) begin : g_oe_comb
      assign hiz_now = hiz_req;
    end else begin : g_oe_reg
      padcell_flop #(.WIDTH(WIDTH), .NEG(OE_NEG), .RST_VAL(OE_RST)) u_oe_reg (
        .clk(clk_oe), .rst(rst), .ce(oe_ce), .d(hiz_req), .q(hiz_now)
      );
    end
  endgenerate

  // output data path
  generate
    if (OUT_MODE == PM_COMB) begin : g_out_comb
      assign out_now = core_dout;
    end else begin : g_out_reg
      padcell_flop #(.WIDTH(WIDTH), .NEG(OUT_NEG), .RST_VAL(OUT_RST)) u_out_reg (
        .clk(clk_out), .rst(rst), .ce(out_en), .d(core_dout), .q(out_now)
      );
    end
  endgenerate

  // pad drivers, one per bit
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign pad[b] = hiz_now[b] ? 1'bz : out_now[b];
      assert_pad_follows_src_R10: assert property (@(posedge clk_out) disable iff (rst)
        !hiz_now[b] |-> (pad_fb[b] === out_now[b]));
    end
  endgenerate

  // R8: raw feedback is always available
  assign pad_fb = pad;

  // input path
  generate
    if (IN_MODE == PM_COMB) begin : g_in_comb
      assign core_din = pad;
    end else if (IN_MODE == PM_LATCH) begin : g_in_latch
      padcell_latch #(.WIDTH(WIDTH), .GATE_LOW(LATCH_GATE_LOW), .RST_VAL(IN_RST)) u_in_latch (
        .gate_clk(clk_in), .rst(rst), .ce(in_en), .d(pad), .q(core_din)
      );
    end else begin : g_in_reg
      padcell_flop #(.WIDTH(WIDTH), .NEG(IN_NEG), .RST_VAL(IN_RST)) u_in_reg (
        .clk(clk_in), .rst(rst), .ce(in_en), .d(pad), .q(core_din)
      );
    end
  endgenerate
endmodule

// File: tb/pad_io_cell_bench.sv
module pad_io_cell_bench;
  import padcell_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst, in_ce, out_ce, oe_ce, io_ce;
  logic [3:0] dout, ctl_a, ctl_b, ctl_c, ctl_d, ext_val;
  logic ext_a, ext_b, ext_c, ext_d;
  wire  [3:0] pad_a, pad_b, pad_c, pad_d;
  logic [3:0] din_a, din_b, din_c, din_d, fb_a, fb_b, fb_c, fb_d;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  assign pad_a = ext_a ? ext_val : 4'bzzzz;
  assign pad_b = ext_b ? ext_val : 4'bzzzz;
  assign pad_c = ext_c ? ext_val : 4'bzzzz;
  assign pad_d = ext_d ? ext_val : 4'bzzzz;

  // A: all rising-edge registers, enable form, active high, default resets
  pad_io_cell u_pad_io_cell (
    .clk_in(clk), .clk_out(clk), .clk_oe(clk), .rst(rst), .in_ce(in_ce), .out_ce(out_ce),
    .oe_ce(oe_ce), .io_ce(io_ce), .core_dout(dout), .drv_ctl(ctl_a), .pad(pad_a),
    .core_din(din_a), .pad_fb(fb_a));

  // B: all falling-edge, tristate form active low, presets, drives from reset
  pad_io_cell #(.IN_NEG(1), .OUT_NEG(1), .OE_NEG(1), .IN_RST_ONE(1), .OUT_RST_ONE(1),
    .OE_RST_HIZ(0), .CTL_IS_TRISTATE(1), .CTL_ACTIVE_LOW(1)) u_pad_io_cell_b (
    .clk_in(clk), .clk_out(clk), .clk_oe(clk), .rst(rst), .in_ce(in_ce), .out_ce(out_ce),
    .oe_ce(oe_ce), .io_ce(io_ce), .core_dout(dout), .drv_ctl(ctl_b), .pad(pad_b),
    .core_din(din_b), .pad_fb(fb_b));

  // C: combinational drive, low-gated latch, enable form active low
  pad_io_cell #(.IN_MODE(PM_LATCH), .OUT_MODE(PM_COMB), .OE_MODE(PM_COMB),
    .LATCH_GATE_LOW(1), .CTL_ACTIVE_LOW(1)) u_pad_io_cell_c (
    .clk_in(clk), .clk_out(clk), .clk_oe(clk), .rst(rst), .in_ce(in_ce), .out_ce(out_ce),
    .oe_ce(oe_ce), .io_ce(io_ce), .core_dout(dout), .drv_ctl(ctl_c), .pad(pad_c),
    .core_din(din_c), .pad_fb(fb_c));

  // D: high-gated latch, tristate form active high
  pad_io_cell #(.IN_MODE(PM_LATCH), .LATCH_GATE_LOW(0), .CTL_IS_TRISTATE(1),
    .CTL_ACTIVE_LOW(0)) u_pad_io_cell_d (
    .clk_in(clk), .clk_out(clk), .clk_oe(clk), .rst(rst), .in_ce(in_ce), .out_ce(out_ce),
    .oe_ce(oe_ce), .io_ce(io_ce), .core_dout(dout), .drv_ctl(ctl_d), .pad(pad_d),
    .core_din(din_d), .pad_fb(fb_d));

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // 2 ns after a rising edge: clock is high
  task automatic at_rise(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    at_rise(1);
    in_ce = 1; out_ce = 1; oe_ce = 1; dout = 4'hF; ctl_a = 4'hF;
    at_rise(2);
    check("R10 pad_a floats in reset", pad_a, 4'bzzzz);
    check("R9 reset beats enable on din_a", din_a, 4'h0);
    check("R5 default data reset 0", din_a, 4'h0);
    check("R6 cleared drive reg drives preset out", pad_b, 4'hF);
    check("R5 preset input register", din_b, 4'hF);
    check("R6 default drive reg floats pad_d", pad_d, 4'bzzzz);
    rst = 0; in_ce = 0; out_ce = 0; oe_ce = 0; ctl_a = 4'h0;
    at_rise(2);
    check("R10 pad_a floats after reset", pad_a, 4'bzzzz);
    check("R4 drive reg holds without oe_ce", pad_b, 4'hF);
  endtask

  task automatic t_drive_a;
    ctl_a = 4'hF; dout = 4'h5; oe_ce = 1; out_ce = 1;
    at_rise(1);
    check("R10 pad_a driven value", pad_a, 4'h5);
    check("R8 feedback equals driven", fb_a, 4'h5);
    check("R4 input reg idle without in_ce", din_a, 4'h0);
    in_ce = 1;
    at_rise(1);
    check("R8 registered read of driven pad", din_a, 4'h5);
    in_ce = 0;
  endtask

  task automatic t_io_ce;
    out_ce = 0; io_ce = 1; dout = 4'hA;
    at_rise(1);
    check("R4 shared enable loads output", pad_a, 4'hA);
    check("R4 shared enable input sees old pad", din_a, 4'h5);
    at_rise(1);
    check("R4 shared enable loads input", din_a, 4'hA);
    io_ce = 0;
  endtask

  task automatic t_oe_ce;
    oe_ce = 0; out_ce = 1; ctl_a = 4'h0; dout = 4'h3;
    at_rise(1);
    check("R4 drive reg held, pad still driven", pad_a, 4'h3);
    oe_ce = 1;
    at_rise(1);
    check("R7 enable form low floats pad_a", pad_a, 4'bzzzz);
  endtask

  task automatic t_both_in;
    in_ce = 1; ext_val = 4'hC; ext_a = 1;
    #1;
    check("R8 feedback immediate", fb_a, 4'hC);
    check("R8 registered copy still old", din_a, 4'hA);
    at_rise(1);
    check("R8 registered copy updates", din_a, 4'hC);
    ext_a = 0; in_ce = 0;
  endtask

  task automatic t_edges;
    at_rise(1);
    ctl_b = 4'hF; ctl_a = 4'hF; dout = 4'h6;
    #1;
    check("R2 falling-edge reg before fall", pad_b, 4'bzzzz);
    #2;
    check("R2 falling-edge reg after fall", pad_b, 4'h6);
    check("R7 tristate active-low deasserted drives", fb_b, 4'h6);
    check("R2 rising-edge reg ignores fall", pad_a, 4'bzzzz);
    #5;
    check("R2 rising-edge reg after rise", pad_a, 4'h6);
    ctl_a = 4'h0; ctl_b = 4'h0;
    at_rise(1);
    check("R7 tristate active-low asserted floats", pad_b, 4'bzzzz);
    ext_val = 4'h9; ext_b = 1; in_ce = 1;
    #3;
    check("R2 falling-edge input capture", din_b, 4'h9);
    ext_b = 0; in_ce = 0;
  endtask

  task automatic t_comb_c;
    ctl_c = 4'h0; dout = 4'h9;
    #1;
    check("R1 combinational drive path", pad_c, 4'h9);
    check("R7 enable active-low asserted drives", fb_c, 4'h9);
    ctl_c = 4'hF;
    #1;
    check("R7 enable active-low deasserted floats", pad_c, 4'bzzzz);
  endtask

  task automatic t_latches;
    in_ce = 1; ext_c = 1; ext_d = 1;
    at_rise(1);
    ext_val = 4'h1;
    #3;
    check("R3 low-gated latch open when clk low", din_c, 4'h1);
    at_rise(1);
    ext_val = 4'h6;
    #1;
    check("R3 low-gated latch holds when clk high", din_c, 4'h1);
    check("R3 high-gated latch open when clk high", din_d, 4'h6);
    #2;
    check("R3 low-gated latch follows again", din_c, 4'h6);
    ext_val = 4'h2;
    #1;
    check("R3 high-gated latch holds when clk low", din_d, 4'h6);
    ext_c = 0; ext_d = 0; in_ce = 0;
  endtask

  task automatic t_drive_d;
    at_rise(1);
    ctl_d = 4'h0; dout = 4'h7; oe_ce = 1; out_ce = 1;
    at_rise(1);
    check("R7 tristate active-high deasserted drives", pad_d, 4'h7);
    ctl_d = 4'hF;
    at_rise(1);
    check("R7 tristate active-high asserted floats", pad_d, 4'bzzzz);
  endtask

  initial begin
    rst = 1; in_ce = 0; out_ce = 0; oe_ce = 0; io_ce = 0; dout = 4'h0;
    ctl_a = 4'h0; ctl_b = 4'h0; ctl_c = 4'hF; ctl_d = 4'hF;
    ext_a = 0; ext_b = 0; ext_c = 0; ext_d = 0; ext_val = 4'h0;
    t_reset();
    t_drive_a();
    t_io_ce();
    t_oe_ce();
    t_both_in();
    t_edges();
    t_comb_c();
    t_latches();
    t_drive_d();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule